// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous static memory with a registered read path and a short burst engine. Each word is split into four byte lanes of eight or nine bits. A transfer begins when the chip is selected and one of two active-low address strobes is seen on a clock edge. Later beats are reached by a two-bit burst counter, which steps in linear or interleaved order. Writes land on the edge that captures the write control, either on all four lanes or on a chosen set of lanes.

Read data passes through two register stages, an array stage and an output stage, before it is driven. The bus therefore turns off two edges after a deselect, not one. The output-enable input gates the drivers with no register in the way. A snooze input stops all array activity. The bus is modelled as a data word plus a drive-enable flag, and a low flag stands for high impedance.

Top module: `burst_sram`

## Requirements
- R1: The chip counts as selected only when `sel_n0`=0, `sel_1`=1 and `sel_n2`=0 (bench encoding {sel_n0,sel_1,sel_n2}=3'b010). A strobe seen while the chip is not selected performs no access, leaves memory unchanged and ends any burst.
- R2: On an edge with either strobe low, the chip selected and `snooze` low, the address is loaded, the burst count is cleared and the first access goes to that address.
- R3: A start with `strb_cpu_n` low is always a read, whatever the write enables are. A start with only `strb_ctl_n` low is a write when `all_wr_n` or `lane_wr_n` is low, and a read otherwise.
- R4: With no strobe and a burst active, `step_n`=0 steps the two-bit count by one, wrapping after four beats. `step_n`=1 repeats the access at the same address. The beat is a write when a write enable is low, and a read otherwise.
- R5: The low two address bits of each beat are start XOR count when `order_ilv`=1, and (start + count) mod 4 when `order_ilv`=0. The upper address bits keep their start value.
- R6: `all_wr_n`=0 writes all four lanes. Otherwise `lane_wr_n`=0 writes each lane i whose `lane_sel_n[i]` is 0. Lane i is word bits [i*LANE_W +: LANE_W].
- R7: A read whose access is made at edge k is driven on `dq_out` with `dq_en`=1 after edge k+1.
- R8: After a deselect, snooze or idle edge k, the word read before it stays driven after edge k, and `dq_en` is 0 after edge k+1.
- R9: A write beat at edge k leaves `dq_en` at 0 after edge k+1. A read at the next edge returns the new data.
- R10: `out_en_n`=1 forces `dq_en` to 0 at once, with no clock edge. Returning it to 0 restores the pipelined word.
- R11: On an edge with `snooze`=1, no access is made, memory is unchanged and any burst ends.
- R12: The synchronous `rst` clears the burst state and both pipeline stages, so `dq_en` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n0 | input | 1 | Chip select, active low |
| sel_1 | input | 1 | Chip select, active high |
| sel_n2 | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Read-only start strobe, active low |
| strb_ctl_n | input | 1 | Read or write start strobe, active low |
| step_n | input | 1 | Burst step (0) or hold (1) |
| all_wr_n | input | 1 | Whole-word write enable, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| order_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| snooze | input | 1 | Standby, blocks all access |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 4*LANE_W | Write data |
| dq_out | output | 4*LANE_W | Read data, zero when not driven |
| dq_en | output | 1 | Bus driven (0 = high impedance) |

## Verification
The bench builds the block with ADDR_W=4 and LANE_W=9, so the whole 16-word array can be filled and read back. The ninth bit of every lane is then checked on both lane and whole-word writes. With four bursts of four words, linear and interleaved orders can be compared from the same start address, and the wrap after four beats stays within a single aligned group.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int unsigned LANES   = 4;
    localparam int unsigned BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic               active;
        logic [BURST_W-1:0] cnt;
    } burst_t;

    // low address bits of a beat
    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        logic [BURST_W-1:0] sum;
        sum = start + cnt;
        return ilv ? (start ^ cnt) : sum;
    endfunction

    // lanes touched by a write
    function automatic logic [LANES-1:0] lane_mask(
        input logic             all_n,
        input logic             lane_n,
        input logic [LANES-1:0] sel_n
    );
        if (!all_n)
            return '1;
        else if (!lane_n)
            return ~sel_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n0,
    input  logic              sel_1,
    input  logic              sel_n2,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              step_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              order_ilv,
    input  logic              snooze,
    input  logic [ADDR_W-1:0] addr,
    output op_e               acc_op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_lanes
);

    burst_t            cur, nxt;
    logic [ADDR_W-1:0] base, nxt_base;
    logic              selected, any_strb, wr_req;

    assign selected = !sel_n0 && sel_1 && !sel_n2;
    assign any_strb = !strb_cpu_n || !strb_ctl_n;
    assign wr_req   = !all_wr_n || !lane_wr_n;

    always_comb begin
        nxt      = cur;
        nxt_base = base;
        acc_op   = OP_IDLE;
        if (snooze) begin
            nxt.active = 1'b0;
        end else if (any_strb) begin
            if (selected) begin
                nxt.active = 1'b1;
                nxt.cnt    = '0;
                nxt_base   = addr;
                acc_op     = (!strb_cpu_n || !wr_req) ? OP_READ : OP_WRITE;
            end else begin
                nxt.active = 1'b0;
            end
        end else if (cur.active) begin
            if (!step_n)
                nxt.cnt = cur.cnt + 1'b1;
            acc_op = wr_req ? OP_WRITE : OP_READ;
        end
    end

    assign acc_addr  = {nxt_base[ADDR_W-1:BURST_W],
                        burst_offset(nxt_base[BURST_W-1:0], nxt.cnt, order_ilv)};
    assign acc_lanes = (acc_op == OP_WRITE) ?
                       lane_mask(all_wr_n, lane_wr_n, lane_sel_n) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            base <= '0;
        end else begin
            cur  <= nxt;
            base <= nxt_base;
        end
    end

    // R4: a step advances the count by one, modulo four
    assert_burst_step_R4: assert property (@(posedge clk) disable iff (rst)
        (cur.active && !snooze && !any_strb && !step_n)
        |=> (cur.cnt == $past(cur.cnt) + 2'd1));

    // R4: hold keeps the beat address
    assert_burst_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cur.active && !snooze && !any_strb && step_n)
        |=> ($stable(cur.cnt) && $stable(base)));

    // R2: a selected strobe loads the address and clears the count
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (!snooze && any_strb && selected)
        |=> (cur.active && base == $past(addr) && cur.cnt == 2'd0));

    // R1: a strobe without selection ends the burst
    assert_deselect_ends_R1: assert property (@(posedge clk) disable iff (rst)
        (!snooze && any_strb && !selected) |=> !cur.active);

    // R11: snooze ends the burst
    assert_snooze_ends_R11: assert property (@(posedge clk) disable iff (rst)
        snooze |=> !cur.active);

endmodule

// File: rtl/bsr_lane.sv
module bsr_lane #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[addr] <= wdata;
        if (re)
            rdata <= cells[addr];
    end

endmodule

// File: rtl/bsr_array.sv
module bsr_array
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  op_e                     acc_op,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        acc_lanes,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    rd_valid,
    output logic [LANES*LANE_W-1:0] rd_data
);

    logic do_read;
    assign do_read = (acc_op == OP_READ);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bsr_lane #(
            .ADDR_W(ADDR_W),
            .LANE_W(LANE_W)
        ) u_lane (
            .clk  (clk),
            .we   ((acc_op == OP_WRITE) && acc_lanes[i]),
            .re   (do_read),
            .addr (acc_addr),
            .wdata(wdata[i*LANE_W +: LANE_W]),
            .rdata(rd_data[i*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_valid <= 1'b0;
        else
            rd_valid <= do_read;
    end

    // R7: a read fills the array stage on the next cycle
    assert_read_fills_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_op == OP_READ) |=> rd_valid);

    // R9: a write beat puts nothing in the read path
    assert_write_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_op == OP_WRITE) |=> !rd_valid);

endmodule

// File: rtl/bsr_outpipe.sv
module bsr_outpipe #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              out_en_n,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_en
);

    logic              out_valid;
    logic [WORD_W-1:0] out_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= in_data;
        end
    end

    assign dq_en  = out_valid && !out_en_n;
    assign dq_out = dq_en ? out_data : '0;

    // R8: an empty array stage turns the bus off one edge later
    assert_second_edge_off_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !dq_en);

    // R7: the output stage presents the word held in the array stage
    assert_word_forward_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_data == $past(in_data)));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel_n0,
    input  logic                    sel_1,
    input  logic                    sel_n2,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    step_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_n,
    input  logic [3:0]              lane_sel_n,
    input  logic                    order_ilv,
    input  logic                    snooze,
    input  logic                    out_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [4*LANE_W-1:0]     wdata,
    output logic [4*LANE_W-1:0]     dq_out,
    output logic                    dq_en
);

    localparam int unsigned WORD_W = LANES * LANE_W;

    op_e               acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_lanes;
    logic              rd_valid;
    logic [WORD_W-1:0] rd_data;

    bsr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sel_n0    (sel_n0),
        .sel_1     (sel_1),
        .sel_n2    (sel_n2),
        .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n),
        .step_n    (step_n),
        .all_wr_n  (all_wr_n),
        .lane_wr_n (lane_wr_n),
        .lane_sel_n(lane_sel_n),
        .order_ilv (order_ilv),
        .snooze    (snooze),
        .addr      (addr),
        .acc_op    (acc_op),
        .acc_addr  (acc_addr),
        .acc_lanes (acc_lanes)
    );

    bsr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .acc_op   (acc_op),
        .acc_addr (acc_addr),
        .acc_lanes(acc_lanes),
        .wdata    (wdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    bsr_outpipe #(.WORD_W(WORD_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .in_valid(rd_valid),
        .in_data (rd_data),
        .out_en_n(out_en_n),
        .dq_out  (dq_out),
        .dq_en   (dq_en)
    );

endmodule

// File: tb/test_burst_sram.sv
`timescale 1ns/100ps
module test_burst_sram;

    localparam int AW = 4;
    localparam int LW = 9;
    localparam int WW = 4 * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          sel_n0 = 1'b0, sel_1 = 1'b1, sel_n2 = 1'b0;
    logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, step_n = 1'b1;
    logic          all_wr_n = 1'b1, lane_wr_n = 1'b1;
    logic [3:0]    lane_sel_n = 4'hF;
    logic          order_ilv = 1'b0, snooze = 1'b0, out_en_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] dq_out;
    logic          dq_en;

    burst_sram #(.ADDR_W(AW), .LANE_W(LW)) i_burst_sram (
        .clk(clk), .rst(rst), .sel_n0(sel_n0), .sel_1(sel_1), .sel_n2(sel_n2),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .order_ilv(order_ilv), .snooze(snooze), .out_en_n(out_en_n),
        .addr(addr), .wdata(wdata), .dq_out(dq_out), .dq_en(dq_en)
    );

    typedef struct {
        int            due;
        bit            valid;
        logic [WW-1:0] data;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0, n_fail = 0, edges = 0;
    bit   done = 1'b0;

    // reference state
    logic [WW-1:0] m_mem [DEPTH];
    bit            m_act = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    // pending settings for the next op, restored after use
    logic [2:0] p_sel = 3'b010;
    bit         p_snz = 1'b0, p_ilv = 1'b0, p_gw = 1'b1, p_bw = 1'b1;
    logic [3:0] p_ln = 4'hF;

    task automatic chk(input bit ok, input string tag, input logic [WW:0] act, input logic [WW:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] pat(input int a, input int s);
        return {9'(a * 7 + s), 9'(a ^ 9'h155), 9'(a * 3 + 9'h101 + s), 9'(a + 9'h0F0)};
    endfunction

    // driver: apply one cycle of stimulus and push the expected bus state
    task automatic op(input string tag, input bit cpu_n, input bit ctl_n,
                      input bit stp_n, input logic [AW-1:0] a, input logic [WW-1:0] d);
        exp_t e;
        bit any, selok, wr;
        int kind;
        logic [1:0] lo;
        logic [AW-1:0] ad;
        @(negedge clk);
        strb_cpu_n = cpu_n; strb_ctl_n = ctl_n; step_n = stp_n;
        addr = a; wdata = d;
        {sel_n0, sel_1, sel_n2} = p_sel;
        snooze = p_snz; order_ilv = p_ilv;
        all_wr_n = p_gw; lane_wr_n = p_bw; lane_sel_n = p_ln;
        any = !cpu_n || !ctl_n;
        selok = (p_sel == 3'b010);
        wr = !p_gw || !p_bw;
        kind = 0;
        if (p_snz) m_act = 1'b0;
        else if (any) begin
            if (selok) begin
                m_act = 1'b1; m_base = a; m_cnt = 2'd0;
                kind = (!cpu_n || !wr) ? 1 : 2;
            end else m_act = 1'b0;
        end else if (m_act) begin
            if (!stp_n) m_cnt = m_cnt + 2'd1;
            kind = wr ? 2 : 1;
        end
        lo = p_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        ad = {m_base[AW-1:2], lo};
        e.due = edges + 2;
        e.tag = tag;
        e.valid = (kind == 1);
        e.data = m_mem[ad];
        if (kind == 2)
            for (int i = 0; i < 4; i++)
                if (!p_gw || (!p_bw && !p_ln[i]))
                    m_mem[ad][i*LW +: LW] = d[i*LW +: LW];
        q.push_back(e);
        p_sel = 3'b010; p_snz = 1'b0; p_ilv = 1'b0;
        p_gw = 1'b1; p_bw = 1'b1; p_ln = 4'hF;
    endtask

    task automatic idle(input string tag);
        op(tag, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic read4(input string tag, input logic [AW-1:0] a, input bit ilv);
        p_ilv = ilv; op(tag, 1'b0, 1'b1, 1'b1, a, '0);
        for (int k = 0; k < 3; k++) begin
            p_ilv = ilv; op(tag, 1'b1, 1'b1, 1'b0, '0, '0);
        end
    endtask

    // monitor: compare the bus against queued expectations
    initial begin
        exp_t e;
        bit exp_en;
        forever begin
            @(posedge clk);
            edges++;
            #1;
            while (q.size() > 0 && q[0].due == edges) begin
                e = q.pop_front();
                exp_en = e.valid && !out_en_n;
                chk((dq_en === exp_en) && (!exp_en || dq_out === e.data), e.tag,
                    {dq_en, dq_out}, {exp_en, e.data});
            end
        end
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R12: reset leaves the bus undriven
        chk(dq_en === 1'b0, "R12 reset state", {dq_en, dq_out}, {1'b0, {WW{1'b0}}});
        rst = 1'b0;

        // R2 R3 R4 R5 R6: fill the array with whole-word linear bursts
        for (int b = 0; b < DEPTH; b += 4) begin
            p_gw = 1'b0; op("R3 ctl write start", 1'b1, 1'b0, 1'b1, AW'(b), pat(b, 0));
            for (int k = 1; k < 4; k++) begin
                p_gw = 1'b0; op("R4 write beat", 1'b1, 1'b1, 1'b0, '0, pat(b + k, 0));
            end
        end
        // R7 R9: read back every word
        for (int b = 0; b < DEPTH; b += 4) read4("R7 linear readback", AW'(b), 1'b0);

        // R5: both orders from start 5, then from 14
        read4("R5 interleaved from 5", 4'd5, 1'b1);
        read4("R5 linear from 5", 4'd5, 1'b0);
        read4("R5 interleaved from 14", 4'd14, 1'b1);
        read4("R5 linear from 14", 4'd14, 1'b0);

        // R4: wrap after four beats, then hold
        op("R4 wrap start", 1'b0, 1'b1, 1'b1, 4'd10, '0);
        for (int k = 0; k < 5; k++) op("R4 wrap step", 1'b1, 1'b1, 1'b0, '0, '0);
        op("R4 hold", 1'b1, 1'b1, 1'b1, '0, '0);
        op("R4 hold", 1'b1, 1'b1, 1'b1, '0, '0);
        op("R4 step after hold", 1'b1, 1'b1, 1'b0, '0, '0);

        // R6: lane writes, lanes 0 and 2 only, then zero lanes
        p_bw = 1'b0; p_ln = 4'b1010;
        op("R6 lane write", 1'b1, 1'b0, 1'b1, 4'd9, pat(99, 3));
        op("R9 read after write", 1'b0, 1'b1, 1'b1, 4'd9, '0);
        p_bw = 1'b0; p_ln = 4'b0111;
        op("R6 lane 3 write", 1'b1, 1'b0, 1'b1, 4'd9, pat(77, 1));
        p_bw = 1'b0; p_ln = 4'hF;
        op("R6 empty lane write", 1'b1, 1'b0, 1'b1, 4'd9, pat(55, 2));
        op("R6 readback", 1'b0, 1'b1, 1'b1, 4'd9, '0);

        // R3: read strobe with whole-word write low stays a read
        p_gw = 1'b0;
        op("R3 cpu strobe reads", 1'b0, 1'b1, 1'b1, 4'd3, pat(66, 6));
        op("R3 memory unchanged", 1'b0, 1'b1, 1'b1, 4'd3, '0);

        // R1: each enable inactive in turn blocks a write
        p_sel = 3'b110; p_gw = 1'b0; op("R1 sel_n0 high", 1'b1, 1'b0, 1'b1, 4'd6, pat(1, 9));
        p_sel = 3'b000; p_gw = 1'b0; op("R1 sel_1 low", 1'b1, 1'b0, 1'b1, 4'd6, pat(2, 9));
        p_sel = 3'b011; p_gw = 1'b0; op("R1 sel_n2 high", 1'b1, 1'b0, 1'b1, 4'd6, pat(3, 9));
        op("R1 continue after deselect", 1'b1, 1'b1, 1'b0, '0, '0);
        op("R1 memory unchanged", 1'b0, 1'b1, 1'b1, 4'd6, '0);

        // R8: read burst then deselect, bus stays one more edge
        op("R8 read", 1'b0, 1'b1, 1'b1, 4'd2, '0);
        op("R8 read", 1'b1, 1'b1, 1'b0, '0, '0);
        p_sel = 3'b110; op("R8 deselect", 1'b0, 1'b1, 1'b1, 4'd0, '0);
        idle("R8 idle");
        idle("R8 idle");

        // R11: snooze blocks a write and ends the burst
        op("R11 read", 1'b0, 1'b1, 1'b1, 4'd1, '0);
        p_snz = 1'b1; p_gw = 1'b0;
        op("R11 snooze write", 1'b1, 1'b0, 1'b1, 4'd0, pat(4, 4));
        op("R11 no resume", 1'b1, 1'b1, 1'b0, '0, '0);
        op("R11 memory unchanged", 1'b0, 1'b1, 1'b1, 4'd0, '0);

        // R10: output enable acts without an edge
        op("R10 read", 1'b0, 1'b1, 1'b1, 4'd1, '0);
        op("R10 hold", 1'b1, 1'b1, 1'b1, '0, '0);
        op("R10 hold", 1'b1, 1'b1, 1'b1, '0, '0);
        @(posedge clk);
        #1.5;
        out_en_n = 1'b1;
        #0.1;
        chk(dq_en === 1'b0, "R10 release", {dq_en, dq_out}, {1'b0, {WW{1'b0}}});
        out_en_n = 1'b0;
        #0.1;
        chk(dq_en === 1'b1 && dq_out === m_mem[1], "R10 restore", {dq_en, dq_out}, {1'b1, m_mem[1]});

        idle("R8 drain");
        idle("R8 drain");
        idle("R8 drain");
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule